// File: doc/BRIEF.md
# Packed Sum-of-Absolute-Differences Engine

The engine measures how far apart two 16x16 blocks of unsigned 16-bit samples are by summing the absolute difference of every co-located sample pair. Samples stream in as pairs of 64-bit words, one word from each block per accepted cycle, with four samples packed in each word. After 64 accepted word pairs (256 sample pairs), the engine reports a single unsigned total and pulses a completion flag.

Each lane forms its absolute difference without a magnitude comparator. It computes two subtractions that clamp at zero, one in each direction, and adds them. Only one of the two can be nonzero. Lane results go into two packed accumulator banks that take turns word by word, so consecutive updates never chain through the same register. The eight lane accumulators are collapsed to one scalar only on the final word. A start pulse abandons any partial block. The engine also re-arms by itself after each result, so blocks can follow one another back to back.

Top module: `packed_sad_engine`

## Requirements
- R1: During and after synchronous active-high reset, `sad_o` is 0, `done_o` is 0 and the word count is zero, so the first block may begin without a start pulse.
- R2: Lane k of a word occupies bits [16k+15:16k] of `x_i` and `y_i`. Each lane contributes exactly |x-y| of its two unsigned samples, including the extremes 0 against 65535 in either order.
- R3: `done_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the 64th word pair of a block, and is low at every other time.
- R4: A word pair is accepted only on a cycle with `valid_i` high. Data present while `valid_i` is low has no effect on the sum or the word count, and idle gaps may occur anywhere.
- R5: `start_i` clears both accumulator banks and the word count. If `valid_i` is high in the same cycle, that word pair becomes word 0 of the new block.
- R6: The result is exact over the full range. A block in which every lane differs by 65535 yields 16,776,960.
- R7: `sad_o` updates only together with `done_o` and holds its value until the next block completes. The next block starts right after completion, without a start pulse.
- R8: Words at even positions in a block (counting from 0) add into one bank and words at odd positions into the other. The reported total covers both banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new block, discarding partial sums |
| valid_i | input | 1 | Word pair on `x_i`/`y_i` is accepted this cycle |
| x_i | input | 64 | Four packed unsigned samples from block X |
| y_i | input | 64 | Four packed unsigned samples from block Y |
| sad_o | output | 24 | Sum of absolute differences of the last completed block |
| done_o | output | 1 | One-cycle pulse when `sad_o` takes a new result |

## Verification
The bench builds the engine with its default parameters: four 16-bit lanes, 64 words per block, 22-bit lane accumulators and a 24-bit result. These defaults make the full-scale block reachable, where each lane accumulator nears its limit and the total lands just under the 24-bit ceiling. With 64 words, the final word has an odd position, so the alternation between the banks and the wrap of the word count are both exercised. Random and directed blocks with idle gaps, restarts and back-to-back runs then reach every path through the word sequencer.

// File: rtl/sad_pkg.sv
package sad_pkg;

    localparam int unsigned SAD_LANE_W      = 16;
    localparam int unsigned SAD_LANES       = 4;
    localparam int unsigned SAD_BLOCK_WORDS = 64;
    localparam int unsigned SAD_ACC_W       = 22;
    localparam int unsigned SAD_SUM_W       = 24;

    // Per-cycle control word issued by the sequencer to every lane.
    typedef struct packed {
        logic clear;   // drop previous bank contents (start pulse)
        logic accept;  // a word pair is taken this cycle
        logic bank;    // 0: even-position bank, 1: odd-position bank
        logic last;    // this word closes the block
    } sad_ctl_t;

endpackage

// File: rtl/sad_sequencer.sv
module sad_sequencer
    import sad_pkg::*;
#(
    parameter int unsigned BLOCK_WORDS = SAD_BLOCK_WORDS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     valid_i,
    output sad_ctl_t ctl_o
);
    localparam int unsigned CNT_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLOCK_WORDS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx;

    always_comb begin
        idx          = start_i ? '0 : cnt_q;
        ctl_o.clear  = start_i;
        ctl_o.accept = valid_i;
        ctl_o.bank   = idx[0];
        ctl_o.last   = valid_i && (idx == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctl_o.last) begin
            cnt_q <= '0;
        end else if (valid_i) begin
            cnt_q <= idx + CNT_W'(1);
        end else begin
            cnt_q <= idx;
        end
    end

    // R5
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (cnt_q == ($past(valid_i) ? CNT_W'(1) : CNT_W'(0))));

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && !start_i) |=> $stable(cnt_q));

endmodule

// File: rtl/sad_lane.sv
module sad_lane
    import sad_pkg::*;
#(
    parameter int unsigned LANE_W = SAD_LANE_W,
    parameter int unsigned ACC_W  = SAD_ACC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  sad_ctl_t          ctl_i,
    input  logic [LANE_W-1:0] x_i,
    input  logic [LANE_W-1:0] y_i,
    output logic [ACC_W:0]    total_o
);
    logic [LANE_W:0]   sub_xy, sub_yx;
    logic [LANE_W-1:0] clamp_xy, clamp_yx, absdiff;
    logic [ACC_W-1:0]  even_q, odd_q, even_nxt, odd_nxt, add_even, add_odd;

    // Two opposing subtractions; a borrow clamps the result to zero.
    always_comb begin
        sub_xy   = {1'b0, x_i} - {1'b0, y_i};
        sub_yx   = {1'b0, y_i} - {1'b0, x_i};
        clamp_xy = sub_xy[LANE_W] ? '0 : sub_xy[LANE_W-1:0];
        clamp_yx = sub_yx[LANE_W] ? '0 : sub_yx[LANE_W-1:0];
        absdiff  = clamp_xy + clamp_yx;
    end

    always_comb begin
        add_even = (ctl_i.accept && !ctl_i.bank) ? ACC_W'(absdiff) : '0;
        add_odd  = (ctl_i.accept &&  ctl_i.bank) ? ACC_W'(absdiff) : '0;
        even_nxt = (ctl_i.clear ? '0 : even_q) + add_even;
        odd_nxt  = (ctl_i.clear ? '0 : odd_q)  + add_odd;
        total_o  = {1'b0, even_nxt} + {1'b0, odd_nxt};
    end

    always_ff @(posedge clk) begin
        if (rst || ctl_i.last) begin
            even_q <= '0;
            odd_q  <= '0;
        end else begin
            even_q <= even_nxt;
            odd_q  <= odd_nxt;
        end
    end

    // R2
    always_comb begin
        if (!$isunknown({x_i, y_i})) begin
            one_side_zero_chk: assert (clamp_xy == '0 || clamp_yx == '0);
        end
    end

    // R8
    bank_alternate_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.accept && !ctl_i.bank && !ctl_i.clear && !ctl_i.last) |=> $stable(odd_q));

endmodule

// File: rtl/sad_reduce.sv
module sad_reduce #(
    parameter int unsigned LANES = 4,
    parameter int unsigned IN_W  = 23,
    parameter int unsigned SUM_W = 24
) (
    input  logic [LANES*IN_W-1:0] lanes_i,
    output logic [SUM_W-1:0]      sum_o
);
    always_comb begin
        sum_o = '0;
        for (int i = 0; i < LANES; i++) begin
            sum_o = sum_o + SUM_W'(lanes_i[i*IN_W +: IN_W]);
        end
    end
endmodule

// File: rtl/packed_sad_engine.sv
module packed_sad_engine
    import sad_pkg::*;
#(
    parameter int unsigned LANE_W      = SAD_LANE_W,
    parameter int unsigned LANES       = SAD_LANES,
    parameter int unsigned BLOCK_WORDS = SAD_BLOCK_WORDS,
    parameter int unsigned ACC_W       = SAD_ACC_W,
    parameter int unsigned SUM_W       = SAD_SUM_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    valid_i,
    input  logic [LANES*LANE_W-1:0] x_i,
    input  logic [LANES*LANE_W-1:0] y_i,
    output logic [SUM_W-1:0]        sad_o,
    output logic                    done_o
);
    localparam int unsigned TOT_W = ACC_W + 1;

    sad_ctl_t                 ctl;
    logic [LANES*TOT_W-1:0]   lane_tot;
    logic [SUM_W-1:0]         block_sum;

    sad_sequencer #(.BLOCK_WORDS(BLOCK_WORDS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .valid_i (valid_i),
        .ctl_o   (ctl)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sad_lane #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .ctl_i   (ctl),
            .x_i     (x_i[g*LANE_W +: LANE_W]),
            .y_i     (y_i[g*LANE_W +: LANE_W]),
            .total_o (lane_tot[g*TOT_W +: TOT_W])
        );
    end

    sad_reduce #(.LANES(LANES), .IN_W(TOT_W), .SUM_W(SUM_W)) u_reduce (
        .lanes_i (lane_tot),
        .sum_o   (block_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sad_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= ctl.last;
            if (ctl.last) begin
                sad_o <= block_sum;
            end
        end
    end

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(sad_o));

endmodule

// File: tb/packed_sad_engine_bench.sv
`timescale 1ns/1ps
module packed_sad_engine_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [63:0] x_i = '0;
    logic [63:0] y_i = '0;
    logic [23:0] sad_o;
    logic        done_o;

    int unsigned tests = 0;
    int unsigned fails = 0;
    int unsigned prev_sad = 0;
    int unsigned seed_init;

    always #2.5 clk = ~clk;

    packed_sad_engine u_packed_sad_engine (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .valid_i (valid_i),
        .x_i     (x_i),
        .y_i     (y_i),
        .sad_o   (sad_o),
        .done_o  (done_o)
    );

    function automatic int unsigned word_sad(input logic [63:0] x, input logic [63:0] y);
        int unsigned s = 0;
        for (int k = 0; k < 4; k++) begin
            int unsigned a = x[16*k +: 16];
            int unsigned b = y[16*k +: 16];
            s += (a > b) ? a - b : b - a;
        end
        return s;
    endfunction

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_word(input logic st, input logic [63:0] x, input logic [63:0] y);
        @(negedge clk);
        start_i = st; valid_i = 1'b1; x_i = x; y_i = y;
        @(posedge clk); #1;
        start_i = 1'b0; valid_i = 1'b0;
    endtask

    task automatic idle(input logic st);
        @(negedge clk);
        start_i = st; valid_i = 1'b0;
        x_i = {$urandom, $urandom}; y_i = {$urandom, $urandom};
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic make_word(input int pat, input int w, output logic [63:0] x, output logic [63:0] y);
        x = {$urandom, $urandom};
        y = {$urandom, $urandom};
        case (pat)
            1: y = x;
            2: begin x = '1; y = '0; end
            3: begin x = (w % 2) ? '1 : '0; y = ~x; end
            4: for (int k = 0; k < 4; k++) y[16*k +: 16] = x[16*k +: 16] ^ 16'($urandom_range(0, 7));
            5: if (w % 2) y = x;
            default: ;
        endcase
    endtask

    // One block of 64 accepted word pairs; checks done timing, sum and result hold.
    task automatic run_block(input int pat, input bit gaps, input bit use_start, input string req);
        int unsigned exp = 0;
        int unsigned early = 0;
        logic [63:0] x, y;
        for (int w = 0; w < 64; w++) begin
            make_word(pat, w, x, y);
            exp += word_sad(x, y);
            if (gaps && $urandom_range(0, 3) == 0) begin
                repeat ($urandom_range(1, 3)) idle(1'b0);
            end
            drive_word(use_start && w == 0, x, y);
            if (w < 63 && done_o) early++;
            if (w == 32) check({req, " R7 result held mid-block"}, sad_o, prev_sad);
        end
        check({req, " R3 done pulse"}, done_o, 1);
        check({req, " sum"}, sad_o, exp);
        check({req, " R3 no early done"}, early, 0);
        prev_sad = exp;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] x, y;
        seed_init = $urandom(32'h5AD0_0C1A);
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 reset sad_o", sad_o, 0);
        check("R1 reset done_o", done_o, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1 idle after reset done_o", done_o, 0);

        // R1/R8: first block right after reset, no start pulse, random data
        run_block(0, 1'b0, 1'b0, "R1 R8 random after reset");
        idle(1'b0);
        check("R3 done drops after one cycle", done_o, 0);
        check("R7 sad_o holds after done", sad_o, prev_sad);

        // R7: back-to-back blocks without start
        run_block(0, 1'b0, 1'b0, "R7 back-to-back");
        // R6: full-scale difference
        run_block(2, 1'b0, 1'b1, "R6 full scale x>y");
        check("R6 exact maximum", sad_o, 16776960);
        run_block(3, 1'b0, 1'b1, "R2 R6 alternating extremes");
        check("R2 extremes both orders", sad_o, 16776960);
        // R2: identical blocks give zero; near values
        run_block(1, 1'b0, 1'b1, "R2 identical words");
        check("R2 zero difference", sad_o, 0);
        run_block(4, 1'b1, 1'b1, "R2 R4 small deltas with gaps");
        // R4: random data with idle gaps carrying garbage
        run_block(0, 1'b1, 1'b0, "R4 random with gaps");
        // R8: only even-position words differ
        run_block(5, 1'b0, 1'b1, "R8 even positions only");

        // R2: single lane directed, lane 2 = 0 vs 65535, others 5 vs 9
        x = {16'd5, 16'd0, 16'd5, 16'd9};
        y = {16'd9, 16'hFFFF, 16'd9, 16'd5};
        drive_word(1'b1, x, y);
        for (int w = 1; w < 64; w++) drive_word(1'b0, '0, '0);
        check("R2 directed lanes", sad_o, 65535 + 12);
        check("R2 directed done", done_o, 1);
        prev_sad = 65535 + 12;

        // R5: restart mid-block with a valid word in the start cycle
        for (int w = 0; w < 20; w++) drive_word(1'b0, {$urandom, $urandom}, {$urandom, $urandom});
        check("R5 no done on partial block", done_o, 0);
        run_block(0, 1'b0, 1'b1, "R5 restart with word");

        // R5: start without valid, then a full block
        for (int w = 0; w < 10; w++) drive_word(1'b0, '1, '0);
        idle(1'b1);
        check("R5 start idle no done", done_o, 0);
        check("R5 start idle holds result", sad_o, prev_sad);
        run_block(0, 1'b1, 1'b0, "R5 start then block");

        idle(1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule